// File: doc/BRIEF.md
# UART In-Band XON/XOFF Flow Controller

This block runs software flow control for one UART channel on its own. It has two directions. In the outgoing direction it watches how full the local receive FIFO is. When the FIFO passes a programmable high threshold, it asks the transmitter to send a stop code (XOFF). When the FIFO drains below a programmable low threshold, it asks the transmitter to send a go code (XON). In the incoming direction it examines each character the receiver delivers. A recognised stop code halts the local transmitter and a recognised go code restarts it. Both of these control characters are removed from the data stream.

Two code pairs, set A and set B, are programmed. Separate mode fields choose which pair the sender uses and which pair the receiver recognises. An option lets any received character restart a halted transmitter. A separate comparator flags one programmable special character. That flag raises an interrupt and stays set until software reads the status.

The transmitter framer sits next to the block. It loads the injected code in place of FIFO data at its next character boundary, and signals that load with `tx_take`.

Top module: `xonxoff_flow_ctl`

## Requirements
- R1: After reset `inj_req` is 0, `tx_enable` is 1, and `remote_held`, `spec_flag` and `spec_irq` are 0.
- R2: In the go state with sending enabled, a cycle with `rx_level` strictly greater than `trig_hi` raises `inj_req` at the next clock edge, with `inj_char` set to the stop code. A level equal to `trig_hi` raises nothing.
- R3: In the stop state (`remote_held`=1), a cycle with `rx_level` strictly below `trig_lo` raises `inj_req` at the next edge, with `inj_char` set to the go code. A level equal to `trig_lo` raises nothing.
- R4: `tx_mode` encoding: 01 sends the set A codes, 10 sends the set B codes, and 00 or 11 disables sending. While sending is disabled, no request is raised, a pending request is dropped, and `remote_held` returns to 0 at the next edge.
- R5: A raised request keeps `inj_req` and `inj_char` steady until a clock edge with `tx_take`=1. At that edge `inj_req` falls and `remote_held` takes the sent kind (1 for a stop code, 0 for a go code).
- R6: `rx_mode` encoding: 01 recognises the set A codes, 10 the set B codes, 11 either set, and 00 none. A recognised stop code sets the halt (`tx_enable`=0) at the next edge. A recognised go code clears it. Both are consumed: `fifo_wr` is 0 in their `rx_valid` cycle.
- R7: A character that is not recognised as a code is passed on: `fifo_wr` equals `rx_valid` in the same cycle.
- R8: With `xon_any`=1, `rx_mode`≠00 and the transmitter halted, any received character that is not a stop code clears the halt at the next edge. Such a character that is not a go code is still passed to the FIFO.
- R9: With `spec_en`=1, a received character equal to `spec_char` sets `spec_flag` at the next edge and is still passed to the FIFO. `spec_irq` equals `spec_flag` AND `spec_irq_en`.
- R10: `status_rd` clears `spec_flag` at the next edge. A new match in the same cycle wins, and the flag stays 1.
- R11: `rx_mode`=00 clears any halt at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | DW | Received character |
| rx_level | input | LW | Local receive FIFO fill level |
| trig_hi | input | LW | Upper threshold (stop code above it) |
| trig_lo | input | LW | Lower threshold (go code below it) |
| tx_mode | input | 2 | Sending code set select |
| rx_mode | input | 2 | Recognised code set select |
| xon_any | input | 1 | Any character restarts a halted transmitter |
| xon_a | input | DW | Go code, set A |
| xoff_a | input | DW | Stop code, set A |
| xon_b | input | DW | Go code, set B |
| xoff_b | input | DW | Stop code, set B |
| spec_en | input | 1 | Special character compare enable |
| spec_char | input | DW | Special character value |
| spec_irq_en | input | 1 | Special character interrupt enable |
| status_rd | input | 1 | Status read strobe, clears the special flag |
| tx_take | input | 1 | Transmitter loads the injected code this cycle |
| inj_req | output | 1 | Injection request to the transmitter |
| inj_char | output | DW | Code to inject |
| fifo_wr | output | 1 | Write the received character into the FIFO |
| tx_enable | output | 1 | Local transmitter allowed to send data |
| remote_held | output | 1 | Last code sent was a stop code |
| spec_flag | output | 1 | Special character seen since last status read |
| spec_irq | output | 1 | Special character interrupt |

## Verification
On every cycle, the assertions check several properties. An injection request and its code hold steady until the transmitter takes them. A take updates the held state. A recognised stop or go code moves the halt state the right way. Disabling reception clears the halt. The special flag obeys set-over-clear. The bench scenarios are needed to show the strict threshold comparisons at their equality edges and the mapping of each mode encoding to its code set. They also show the pass-or-consume decision on `fifo_wr`, the "any character" restart, and the full round trip of a stop code and then a go code through the take handshake.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    FC_OFF   = 2'b00,
    FC_SET_A = 2'b01,
    FC_SET_B = 2'b10,
    FC_BOTH  = 2'b11
  } fc_mode_e;

  // true when the sending side is active for the given mode field
  function automatic logic fc_send_on(input logic [1:0] mode);
    return (mode == FC_SET_A) || (mode == FC_SET_B);
  endfunction
endpackage

// File: rtl/fc_level_mon.sv
module fc_level_mon #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_on,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] trig_hi,
  input  logic [LW-1:0] trig_lo,
  input  logic          take,
  output logic          req,
  output logic          req_stop,
  output logic          held
);
  logic req_q, req_d, kind_q, kind_d, held_q, held_d;

  always_comb begin
    req_d  = req_q;
    kind_d = kind_q;
    held_d = held_q;
    if (!mode_on) begin
      req_d  = 1'b0;
      kind_d = 1'b0;
      held_d = 1'b0;
    end else if (req_q) begin
      if (take) begin
        req_d  = 1'b0;
        held_d = kind_q;
      end
    end else if (!held_q && (level > trig_hi)) begin
      req_d  = 1'b1;
      kind_d = 1'b1;
    end else if (held_q && (level < trig_lo)) begin
      req_d  = 1'b1;
      kind_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      kind_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      kind_q <= kind_d;
      held_q <= held_d;
    end
  end

  assign req      = req_q;
  assign req_stop = kind_q;
  assign held     = held_q;

  // R5: request and its kind stay put until taken
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !take && mode_on) |=> (req_q && $stable(kind_q)));
  // R5: a take retires the request and records the kind sent
  p_take_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && take && mode_on) |=> (!req_q && (held_q == $past(kind_q))));
  // R4: disabled sending leaves nothing pending and the go state
  p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |=> (!req_q && !held_q));
endmodule

// File: rtl/fc_rx_match.sv
module fc_rx_match
  import fc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_char,
  input  logic [1:0]    rx_mode,
  input  logic          xon_any,
  input  logic [DW-1:0] xon_a,
  input  logic [DW-1:0] xoff_a,
  input  logic [DW-1:0] xon_b,
  input  logic [DW-1:0] xoff_b,
  output logic          paused,
  output logic          fifo_wr
);
  logic hit_stop, hit_go, consume, resume_any;
  logic paused_q, paused_d;

  always_comb begin
    unique case (fc_mode_e'(rx_mode))
      FC_SET_A: begin
        hit_stop = (rx_char == xoff_a);
        hit_go   = (rx_char == xon_a);
      end
      FC_SET_B: begin
        hit_stop = (rx_char == xoff_b);
        hit_go   = (rx_char == xon_b);
      end
      FC_BOTH: begin
        hit_stop = (rx_char == xoff_a) || (rx_char == xoff_b);
        hit_go   = (rx_char == xon_a) || (rx_char == xon_b);
      end
      default: begin
        hit_stop = 1'b0;
        hit_go   = 1'b0;
      end
    endcase
  end

  assign consume    = rx_valid && (hit_stop || hit_go);
  assign resume_any = rx_valid && xon_any && paused_q &&
                      (rx_mode != FC_OFF) && !hit_stop;
  assign fifo_wr    = rx_valid && !consume;

  always_comb begin
    paused_d = paused_q;
    if (rx_mode == FC_OFF)          paused_d = 1'b0;
    else if (rx_valid && hit_stop)  paused_d = 1'b1;
    else if (rx_valid && hit_go)    paused_d = 1'b0;
    else if (resume_any)            paused_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) paused_q <= 1'b0;
    else        paused_q <= paused_d;
  end

  assign paused = paused_q;

  // R6: a recognised stop code halts the transmitter
  p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && hit_stop && rx_mode != FC_OFF) |=> paused_q);
  // R6: a recognised code never reaches the FIFO
  p_code_consumed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (hit_stop || hit_go)) |-> !fifo_wr);
  // R6: a recognised go code releases the halt
  p_go_resumes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && hit_go && !hit_stop) |=> !paused_q);
  // R11: disabled reception releases the halt
  p_off_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode == FC_OFF) |=> !paused_q);
endmodule

// File: rtl/fc_spec_det.sv
module fc_spec_det #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_char,
  input  logic          spec_en,
  input  logic [DW-1:0] spec_char,
  input  logic          status_rd,
  output logic          flag
);
  logic hit, flag_q, flag_d;

  assign hit = rx_valid && spec_en && (rx_char == spec_char);

  always_comb begin
    flag_d = flag_q;
    if (hit)            flag_d = 1'b1;
    else if (status_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  // R9, R10: a match always leaves the flag set
  p_match_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q);
  // R10: a status read without a match clears it
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !hit) |=> !flag_q);
endmodule

// File: rtl/xonxoff_flow_ctl.sv
module xonxoff_flow_ctl
  import fc_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_char,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] trig_hi,
  input  logic [LW-1:0] trig_lo,
  input  logic [1:0]    tx_mode,
  input  logic [1:0]    rx_mode,
  input  logic          xon_any,
  input  logic [DW-1:0] xon_a,
  input  logic [DW-1:0] xoff_a,
  input  logic [DW-1:0] xon_b,
  input  logic [DW-1:0] xoff_b,
  input  logic          spec_en,
  input  logic [DW-1:0] spec_char,
  input  logic          spec_irq_en,
  input  logic          status_rd,
  input  logic          tx_take,
  output logic          inj_req,
  output logic [DW-1:0] inj_char,
  output logic          fifo_wr,
  output logic          tx_enable,
  output logic          remote_held,
  output logic          spec_flag,
  output logic          spec_irq
);
  logic send_on, req_stop, paused;

  assign send_on = fc_send_on(tx_mode);

  fc_level_mon #(.LW(LW)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_on  (send_on),
    .level    (rx_level),
    .trig_hi  (trig_hi),
    .trig_lo  (trig_lo),
    .take     (tx_take),
    .req      (inj_req),
    .req_stop (req_stop),
    .held     (remote_held)
  );

  always_comb begin
    if (tx_mode == FC_SET_B) inj_char = req_stop ? xoff_b : xon_b;
    else                     inj_char = req_stop ? xoff_a : xon_a;
  end

  fc_rx_match #(.DW(DW)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_char  (rx_char),
    .rx_mode  (rx_mode),
    .xon_any  (xon_any),
    .xon_a    (xon_a),
    .xoff_a   (xoff_a),
    .xon_b    (xon_b),
    .xoff_b   (xoff_b),
    .paused   (paused),
    .fifo_wr  (fifo_wr)
  );

  assign tx_enable = !paused;

  fc_spec_det #(.DW(DW)) u_spec (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_char   (rx_char),
    .spec_en   (spec_en),
    .spec_char (spec_char),
    .status_rd (status_rd),
    .flag      (spec_flag)
  );

  assign spec_irq = spec_flag && spec_irq_en;

  // R7: an unrecognised character in reception-off mode is always written
  p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_mode == FC_OFF) |-> fifo_wr);
endmodule

// File: tb/xonxoff_flow_ctl_test.sv
module xonxoff_flow_ctl_test;
  localparam int DW = 8;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic rx_valid, xon_any, spec_en, spec_irq_en, status_rd, tx_take;
  logic [DW-1:0] rx_char, xon_a, xoff_a, xon_b, xoff_b, spec_char;
  logic [LW-1:0] rx_level, trig_hi, trig_lo;
  logic [1:0] tx_mode, rx_mode;
  logic inj_req, fifo_wr, tx_enable, remote_held, spec_flag, spec_irq;
  logic [DW-1:0] inj_char;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xonxoff_flow_ctl #(.DW(DW), .LW(LW)) uut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rx(input logic [DW-1:0] c);
    rx_valid = 1'b1; rx_char = c;
  endtask

  task automatic t_reset();
    chk("R1 inj_req", inj_req, 0);
    chk("R1 tx_enable", tx_enable, 1);
    chk("R1 remote_held", remote_held, 0);
    chk("R1 spec_flag", spec_flag, 0);
    chk("R1 spec_irq", spec_irq, 0);
  endtask

  task automatic t_set_a_round_trip();
    tx_mode = 2'b01; trig_lo = 8'd4; trig_hi = 8'd10;
    rx_level = 8'd10; step();
    chk("R2 equal hi no req", inj_req, 0);
    rx_level = 8'd11; step();
    chk("R2 req", inj_req, 1);
    chk("R2 char stop A", inj_char, xoff_a);
    step(); step();
    chk("R5 held req", inj_req, 1);
    chk("R5 held char", inj_char, xoff_a);
    chk("R5 not yet held", remote_held, 0);
    tx_take = 1'b1; step(); tx_take = 1'b0;
    chk("R5 req retired", inj_req, 0);
    chk("R5 remote_held", remote_held, 1);
    step();
    chk("R2 no repeat", inj_req, 0);
    rx_level = 8'd4; step();
    chk("R3 equal lo no req", inj_req, 0);
    rx_level = 8'd3; step();
    chk("R3 req", inj_req, 1);
    chk("R3 char go A", inj_char, xon_a);
    tx_take = 1'b1; step(); tx_take = 1'b0;
    chk("R5 go sent", remote_held, 0);
    chk("R5 go retired", inj_req, 0);
  endtask

  task automatic t_set_b_and_off();
    tx_mode = 2'b10; rx_level = 8'd20; step();
    chk("R4 set B req", inj_req, 1);
    chk("R4 set B stop", inj_char, xoff_b);
    tx_mode = 2'b00; step();
    chk("R4 off drops req", inj_req, 0);
    chk("R4 off go state", remote_held, 0);
    tx_mode = 2'b11; step(); step();
    chk("R4 mode 11 no req", inj_req, 0);
    tx_mode = 2'b01; rx_level = 8'd20; step();
    tx_take = 1'b1; step(); tx_take = 1'b0;
    chk("R4 held before off", remote_held, 1);
    tx_mode = 2'b00; step();
    chk("R4 off clears held", remote_held, 0);
    rx_level = 8'd5;
  endtask

  task automatic t_rx_set_a();
    rx_mode = 2'b01;
    rx(xoff_a); #0;
    #1 chk("R6 stop consumed", fifo_wr, 0);
    step(); rx_valid = 1'b0;
    chk("R6 halted", tx_enable, 0);
    rx(8'h41); #1;
    chk("R7 data passed", fifo_wr, 1);
    step(); rx_valid = 1'b0;
    chk("R6 still halted", tx_enable, 0);
    rx(xon_a); #1;
    chk("R6 go consumed", fifo_wr, 0);
    step(); rx_valid = 1'b0;
    chk("R6 resumed", tx_enable, 1);
    rx(xoff_b); #1;
    chk("R7 other set passed", fifo_wr, 1);
    step(); rx_valid = 1'b0;
    chk("R6 other set ignored", tx_enable, 1);
  endtask

  task automatic t_rx_both();
    rx_mode = 2'b11;
    rx(xoff_b); step(); rx_valid = 1'b0;
    chk("R6 both: B stop halts", tx_enable, 0);
    rx(xon_a); step(); rx_valid = 1'b0;
    chk("R6 both: A go resumes", tx_enable, 1);
    rx_mode = 2'b10;
    rx(xoff_a); #1;
    chk("R7 set B passes A stop", fifo_wr, 1);
    step(); rx_valid = 1'b0;
    chk("R6 set B ignores A stop", tx_enable, 1);
  endtask

  task automatic t_xon_any();
    rx_mode = 2'b01; xon_any = 1'b1;
    rx(xoff_a); step(); rx_valid = 1'b0;
    chk("R8 halted", tx_enable, 0);
    rx(xoff_a); step(); rx_valid = 1'b0;
    chk("R8 stop keeps halt", tx_enable, 0);
    rx(8'h55); #1;
    chk("R8 char passed", fifo_wr, 1);
    step(); rx_valid = 1'b0;
    chk("R8 any resumes", tx_enable, 1);
    xon_any = 1'b0;
    rx(xoff_a); step(); rx_valid = 1'b0;
    rx(8'h55); step(); rx_valid = 1'b0;
    chk("R8 option off keeps halt", tx_enable, 0);
    rx_mode = 2'b00; step();
    chk("R11 off releases", tx_enable, 1);
    rx(xoff_a); #1;
    chk("R7 off passes code", fifo_wr, 1);
    step(); rx_valid = 1'b0;
    chk("R11 off ignores stop", tx_enable, 1);
  endtask

  task automatic t_special();
    spec_en = 1'b1; spec_char = 8'h2A; spec_irq_en = 1'b0;
    rx(8'h2A); #1;
    chk("R9 special passed", fifo_wr, 1);
    step(); rx_valid = 1'b0;
    chk("R9 flag", spec_flag, 1);
    chk("R9 irq masked", spec_irq, 0);
    spec_irq_en = 1'b1; #1;
    chk("R9 irq", spec_irq, 1);
    status_rd = 1'b1; step(); status_rd = 1'b0;
    chk("R10 cleared", spec_flag, 0);
    rx(8'h2A); status_rd = 1'b1; step(); rx_valid = 1'b0; status_rd = 1'b0;
    chk("R10 set wins", spec_flag, 1);
    status_rd = 1'b1; step(); status_rd = 1'b0;
    spec_en = 1'b0; rx(8'h2A); step(); rx_valid = 1'b0;
    chk("R9 disabled no flag", spec_flag, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_valid = 0; rx_char = 0; rx_level = 0;
    trig_hi = 8'd10; trig_lo = 8'd4; tx_mode = 0; rx_mode = 0;
    xon_any = 0; spec_en = 0; spec_irq_en = 0; status_rd = 0; tx_take = 0;
    xon_a = 8'h11; xoff_a = 8'h13; xon_b = 8'h91; xoff_b = 8'h93;
    spec_char = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_set_a_round_trip();
    t_set_b_and_off();
    t_rx_set_a();
    t_rx_both();
    t_xon_any();
    t_special();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule